// File: doc/BRIEF.md
# Nibble-Multiplexed Key Code Bridge

This block hands 8-bit key codes from an internal producer to a host that can see only a narrow, controller-style port. The port has one select line driven by the host, one ready line and four data lines. The producer pushes codes into a small ring buffer. The bridge takes one code at a time from that buffer and shifts it, most significant bit first, into an 8-bit holding register. The host then reads the register as two 4-bit halves, using its select line to choose which half is shown.

The select line also acts as the acknowledge. A set/reset ready latch is set whenever select is high. The bridge may load a new code only while that latch is set. When a load finishes, the bridge clears the latch with a one-cycle pulse, and the ready line goes low. So ready low tells the host that a fresh code is waiting. Raising select to read the upper half also tells the bridge that the code has been taken.

The latch comes out of reset cleared. The host must therefore give one dummy select-high pulse at start-up before the first code can be loaded.

Top module: `kc_nibble_bridge`

## Requirements
- R1: While reset is active and right after it, host_rdy is 0, host_nib is 0 and push_drop is 0.
- R2: host_nib shows bits 3:0 of the holding register while host_sel is 0. It shows bits 7:4 while host_sel is 1. It follows host_sel combinationally.
- R3: host_sel sampled high at a clock edge sets host_rdy to 1 after that edge. If host_sel is high in the same cycle as the bridge's clear pulse, the latch stays set.
- R4: A code is loaded only while host_rdy is 1. Before the first select-high pulse after reset, queued codes are not loaded: host_rdy stays 0 and host_nib stays 0.
- R5: A load shifts exactly 8 bits, one per clock, MSB first. Take a one-cycle select pulse sampled at edge A, with the bridge idle and a code queued. host_rdy is still 1 after edge A+9 and falls at edge A+10.
- R6: Codes are delivered in the order they were pushed. The buffer pointers wrap around the buffer.
- R7: A push into a full buffer (DEPTH codes queued) is dropped. push_drop is 1 for exactly the one cycle after that edge, and the dropped code is never delivered.
- R8: The holding register changes only during a load. After a delivery, host_nib stays at the delivered code for as long as no new load starts.
- R9: No load starts while another load or its clear pulse is in progress. With host_sel held high across two back-to-back loads, the second code arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer writes push_code this cycle |
| push_code | input | 8 | Key code from the producer |
| push_drop | output | 1 | One-cycle pulse: the last push found the buffer full |
| host_sel | input | 1 | Host nibble select; high also sets the ready latch |
| host_rdy | output | 1 | Ready latch output; 0 means a new code is waiting |
| host_nib | output | 4 | Selected half of the holding register |

## Verification
The assertions assume that host_sel is synchronous to clk and settles away from the active edge, as if it had already passed through a synchronizer. They also assume that the producer never depends on a dropped push. The bench changes host_sel and push_valid only on falling edges. It gives a select pulse only after it has read the low half, or else holds select high on purpose, and it fills the buffer only while the latch is cleared.

// File: rtl/kc_nibble_bridge.sv
module kc_nibble_bridge #(
  parameter int DEPTH = 4,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [2*NIB_W-1:0] push_code,
  output logic             push_drop,
  input  logic             host_sel,
  output logic             host_rdy,
  output logic [NIB_W-1:0] host_nib
);
  localparam int CODE_W = 2 * NIB_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SC_W   = $clog2(CODE_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [SC_W-1:0]  SC_LAST  = SC_W'(CODE_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_CLR} state_t;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [CODE_W-1:0] tx, hold;
  logic [SC_W-1:0]   sc;
  state_t            state;
  logic              latch_q;

  wire full     = (count == CNT_FULL);
  wire empty    = (count == '0);
  wire do_push  = push_valid && !full;
  wire do_pop   = (state == ST_IDLE) && latch_q && !empty;
  wire clr_rdy  = (state == ST_CLR);
  wire shift_en = (state == ST_SHIFT);

  assign host_rdy = latch_q;
  assign host_nib = host_sel ? hold[CODE_W-1:NIB_W] : hold[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      push_drop <= 1'b0;
    end else begin
      push_drop <= push_valid && full;
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sc    <= '0;
      tx    <= '0;
      hold  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (do_pop) begin
          tx    <= mem[rd_ptr];
          sc    <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          hold <= {hold[CODE_W-2:0], tx[CODE_W-1]};
          tx   <= {tx[CODE_W-2:0], 1'b0};
          sc   <= sc + 1'b1;
          if (sc == SC_LAST) state <= ST_CLR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (host_sel) latch_q <= 1'b1;
    else if (clr_rdy)  latch_q <= 1'b0;
  end

  // R3
  sel_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |=> host_rdy);

  // R4
  load_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !host_rdy) |=> (state != ST_SHIFT));

  // R5
  rdy_fall_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rdy) |-> ($past(shift_en, 2) && !$past(host_sel)));

  // R5
  clr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rdy |=> !clr_rdy);

  // R7
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |-> $past(push_valid && full));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hold));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && sc != SC_LAST) |=> shift_en);
endmodule

// File: tb/kc_nibble_bridge_test.sv
module kc_nibble_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [7:0] push_code = '0;
  logic push_drop;
  logic host_sel = 1'b0;
  logic host_rdy;
  logic [3:0] host_nib;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kc_nibble_bridge uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_code(push_code),
    .push_drop(push_drop), .host_sel(host_sel), .host_rdy(host_rdy), .host_nib(host_nib)
  );

  // {code, expected high nibble, expected low nibble}
  localparam logic [15:0] VEC [8] = '{
    16'hA5_A5, 16'h0F_0F, 16'hF0_F0, 16'h81_81,
    16'h7E_7E, 16'h3C_3C, 16'hFF_FF, 16'h01_01
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk); push_valid = 1'b1; push_code = c;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic pulse_sel();
    @(negedge clk); host_sel = 1'b1;
    @(negedge clk); host_sel = 1'b0;
  endtask

  task automatic read_code(input string req, input logic [3:0] hi, input logic [3:0] lo);
    int n = 0;
    @(negedge clk);
    while (host_rdy !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk({req, " ready"}, {7'd0, host_rdy}, 8'd0);
    #1 chk({req, " low nibble"}, {4'd0, host_nib}, {4'd0, lo});
    host_sel = 1'b1;
    #1 chk({req, " high nibble"}, {4'd0, host_nib}, {4'd0, hi});
    host_sel = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdy", {7'd0, host_rdy}, 8'd0);
    chk("R1 nib", {4'd0, host_nib}, 8'd0);
    chk("R1 drop", {7'd0, push_drop}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after reset", {7'd0, host_rdy}, 8'd0);

    // R7 fill to full, fifth push dropped
    push(8'h12); push(8'h34); push(8'h56); push(8'h78);
    @(negedge clk); push_valid = 1'b1; push_code = 8'h9A;
    @(negedge clk); push_valid = 1'b0;
    chk("R7 drop pulse", {7'd0, push_drop}, 8'd1);
    @(negedge clk);
    chk("R7 drop one cycle", {7'd0, push_drop}, 8'd0);

    // R4 nothing loads before the dummy pulse
    repeat (20) @(negedge clk);
    chk("R4 rdy held low", {7'd0, host_rdy}, 8'd0);
    chk("R4 nib untouched", {4'd0, host_nib}, 8'd0);

    // dummy start-up pulse, then R6 order; R2 nibble selection
    pulse_sel();
    read_code("R6 first", 4'h1, 4'h2);

    // R5 timing: select sampled at edge A, fall at A+10
    @(negedge clk); host_sel = 1'b1;
    @(negedge clk); host_sel = 1'b0;
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R5 rdy after A+9", {7'd0, host_rdy}, 8'd1);
    @(posedge clk); @(negedge clk);
    chk("R5 rdy at A+10", {7'd0, host_rdy}, 8'd0);
    read_code("R2 second", 4'h3, 4'h4);
    pulse_sel();
    read_code("R6 third", 4'h5, 4'h6);
    pulse_sel();
    read_code("R6 fourth", 4'h7, 4'h8);
    pulse_sel();

    // R7 dropped code never shows; R8 holding register stable
    repeat (30) @(negedge clk);
    chk("R7 no dropped delivery rdy", {7'd0, host_rdy}, 8'd1);
    #1 chk("R8 hold low nibble", {4'd0, host_nib}, 8'h08);
    host_sel = 1'b1;
    #1 chk("R8 hold high nibble", {4'd0, host_nib}, 8'h07);
    host_sel = 1'b0;

    // R6 wrap-around and R2 patterns from the vector table
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][15:8]);
      read_code("R6 table", VEC[i][7:4], VEC[i][3:0]);
      pulse_sel();
    end

    // R9 / R3: select held high across two back-to-back loads
    @(negedge clk); host_sel = 1'b1;
    push(8'hC3); push(8'h3C);
    repeat (40) @(negedge clk);
    chk("R3 set wins over clear", {7'd0, host_rdy}, 8'd1);
    #1 chk("R9 second code high", {4'd0, host_nib}, 8'h03);
    host_sel = 1'b0;
    #1 chk("R9 second code low", {4'd0, host_nib}, 8'h0C);
    @(negedge clk);
    chk("R3 rdy stays set", {7'd0, host_rdy}, 8'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule